// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges four independent reset causes into one system reset line. The first cause is an active-low external pin, accepted only after a glitch filter. The other three are a software request, a watchdog expiry and a conflict between hard-trap priority levels. Each cause is applied under its own rule. A pin pulse must stay low for a minimum number of clock cycles before it counts. A software request produces a reset exactly one cycle long. A watchdog expiry asserts the reset combinationally and is released through a deassertion synchronizer. A trap conflict is found by comparing the level now being serviced with the level of an incoming trap.

A 16-bit status word records which cause fired. Its flags are sticky, survive the resets they record, and are cleared only when software writes a zero to the bit. When the core is asleep or idle, a watchdog expiry does not reset it. The block issues a wake request instead and leaves the watchdog flag alone.

The block's own flops use a synchronous active-low reset. That reset is meant for power-up only. The block never resets itself from `sys_rst_o`.

Top module: `rstctl_top`

## Requirements
- R1: After two synchronizer stages, the pin input feeds a counter of consecutive low cycles.
  - A low pulse seen by L rising edges produces a reset only when L >= MIN_PULSE (default 8).
  - Such a pulse holds `sys_rst_o` high for exactly L - MIN_PULSE + 1 cycles.
  - A shorter pulse leaves `sys_rst_o` low.
- R2: A qualified pin reset sets status bit 7. A pulse too short to qualify leaves bit 7 clear.
- R3: A one-cycle `sw_rst_i` strobe drives `sys_rst_o` high for exactly one cycle, starting one cycle later, and sets status bit 6.
- R4: A watchdog expiry (`wdt_to_i` high) while neither `sleep_i` nor `idle_i` is high has three effects.
  - It raises `sys_rst_o` combinationally, in the same cycle and before any clock edge.
  - It sets status bit 4.
  - A one-cycle expiry keeps the reset high for REL_STAGES (default 2) sampled cycles in total.
- R5: A watchdog expiry while `sleep_i` or `idle_i` is high produces a one-cycle `wake_o` pulse on the next cycle. It does not raise `sys_rst_o` and does not set status bit 4.
- R6: A trap is hard when its 4-bit level is 13, 14 or 15. A trap conflict occurs when all three of the following hold in the same cycle:
  - `trap_new_i` is high;
  - both `trap_cur_lvl_i` and `trap_new_lvl_i` are hard;
  - the current level is below the new one.
  A conflict drives `sys_rst_o` high for one cycle, starting one cycle later, and sets status bit 15. Any other level pair does neither.
- R7: Causes that arrive in the same cycle set all of their flags together. The reset lasts as long as the longest of them.
- R8: Status flag behaviour:
  - Flags are sticky across later resets.
  - A write with `stat_wr_i` clears exactly the flag bits whose `stat_wdata_i` bit is 0.
  - A flag set in the same cycle as a clearing write stays set.
  - Bits other than 15, 7, 6 and 4 always read 0.
- R9: While `rst_ni` is low and right after it is released, `status_o` is 0, `sys_rst_o` is 0 and `wake_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low power-up reset of the controller |
| ext_rst_ni | input | 1 | Raw active-low external reset pin |
| sw_rst_i | input | 1 | Software reset strobe |
| wdt_to_i | input | 1 | Watchdog time-out pulse |
| sleep_i | input | 1 | Core is in sleep mode |
| idle_i | input | 1 | Core is in idle mode |
| trap_cur_lvl_i | input | 4 | Priority level of the trap being serviced (0 = none) |
| trap_new_i | input | 1 | An incoming trap is presented this cycle |
| trap_new_lvl_i | input | 4 | Priority level of the incoming trap |
| stat_wr_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 16 | Status write data; a 0 clears that flag |
| sys_rst_o | output | 1 | System reset, active high |
| wake_o | output | 1 | Wake request to the core |
| status_o | output | 16 | Sticky reset-cause flags |

## Verification
The situation hardest to reach is a watchdog expiry that lands in the same cycle as other causes. In that case the reset must stretch to the longest cause, and every flag must be set together. It is just as hard to show that the reset rises before any clock edge. The bench drives the software strobe, a hard-trap conflict and the watchdog pulse in one cycle and counts the reset cycles. Separately, it samples `sys_rst_o` one nanosecond after raising `wdt_to_i`, mid-cycle. The pin filter is swept over pulse lengths on both sides of the threshold, and all 256 trap level pairs are tried.

// File: rtl/rstctl_pkg.sv
// Package: shared constants for the reset controller.
// Fixes the status flag positions and the hard-trap level range.
package rstctl_pkg;
    localparam int STAT_W    = 16;
    localparam int LVL_W     = 4;
    localparam int FLAG_TRAP = 15;
    localparam int FLAG_EXT  = 7;
    localparam int FLAG_SW   = 6;
    localparam int FLAG_WDT  = 4;
    localparam int HARD_LO   = 13;
    localparam int HARD_HI   = 15;
    localparam logic [STAT_W-1:0] FLAG_MASK =
        (STAT_W'(1) << FLAG_TRAP) | (STAT_W'(1) << FLAG_EXT) |
        (STAT_W'(1) << FLAG_SW)   | (STAT_W'(1) << FLAG_WDT);
endpackage

// File: rtl/rstctl_pin_filter.sv
// Module: external pin synchronizer and minimum-width filter.
// Assumes the pin is asynchronous and active low.
// qual_o is high while the synchronized pin has stayed low for at least MIN_W consecutive cycles.
module rstctl_pin_filter #(
    parameter int MIN_W = 8
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_ni,
    output logic qual_o
);
    localparam int CNT_W = $clog2(MIN_W + 1);
    localparam logic [CNT_W-1:0] MIN_CNT = CNT_W'(MIN_W);

    logic [1:0]       sync_q;
    logic [CNT_W-1:0] cnt_q;

    // Two-flop synchronizer; idles high (pin released).
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sync_q <= 2'b11;
        else         sync_q <= {sync_q[0], pin_ni};
    end

    // Saturating count of consecutive synchronized low cycles.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)              cnt_q <= '0;
        else if (sync_q[1])       cnt_q <= '0;
        else if (cnt_q != MIN_CNT) cnt_q <= cnt_q + 1'b1;
    end

    assign qual_o = (cnt_q == MIN_CNT);
endmodule

// File: rtl/rstctl_trap_detect.sv
// Module: hard-trap conflict detector.
// A conflict is a valid incoming hard trap whose level is above the hard level currently being serviced.
// Purely combinational; the caller registers the result.
module rstctl_trap_detect
    import rstctl_pkg::*;
(
    input  logic             new_i,
    input  logic [LVL_W-1:0] cur_lvl_i,
    input  logic [LVL_W-1:0] new_lvl_i,
    output logic             conflict_o
);
    localparam logic [LVL_W-1:0] LO = LVL_W'(HARD_LO);
    localparam logic [LVL_W-1:0] HI = LVL_W'(HARD_HI);

    logic cur_hard, new_hard;

    // Classify both levels and compare priority.
    always_comb begin
        cur_hard   = (cur_lvl_i >= LO) && (cur_lvl_i <= HI);
        new_hard   = (new_lvl_i >= LO) && (new_lvl_i <= HI);
        conflict_o = new_i && cur_hard && new_hard && (cur_lvl_i < new_lvl_i);
    end
endmodule

// File: rtl/rstctl_release_sync.sv
// Module: asynchronous-assert, synchronous-release stretcher.
// Assumes STAGES >= 2.
// The output follows hit_i at once and drops STAGES clock edges after hit_i goes away.
module rstctl_release_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    output logic rst_o
);
    logic [STAGES-1:0] st_q;

    // Load all ones on a hit; otherwise shift zeros toward the output stage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)    st_q <= '0;
        else if (hit_i) st_q <= '1;
        else            st_q <= {st_q[STAGES-2:0], 1'b0};
    end

    assign rst_o = hit_i | st_q[STAGES-1];
endmodule

// File: rtl/rstctl_status_reg.sv
// Module: sticky reset-cause flags.
// Each flag is set by its cause and cleared by a write of zero to that bit.
// Set wins over clear; bits outside FLAG_MASK read zero.
module rstctl_status_reg
    import rstctl_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [STAT_W-1:0] set_i,
    input  logic              wr_i,
    input  logic [STAT_W-1:0] wdata_i,
    output logic [STAT_W-1:0] stat_o
);
    logic [STAT_W-1:0] stat_q, keep;

    // Bits kept after an optional software write.
    always_comb keep = wr_i ? (stat_q & wdata_i) : stat_q;

    // Flag update: keep, then merge new causes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) stat_q <= '0;
        else         stat_q <= (keep | set_i) & FLAG_MASK;
    end

    assign stat_o = stat_q;
endmodule

// File: rtl/rstctl_top.sv
// Module: multi-source reset controller top.
// Merges the filtered pin, software strobe, watchdog time-out and trap conflict into sys_rst_o, and records the causes.
// A watchdog time-out in sleep or idle becomes a one-cycle wake request.
// rst_ni is the controller's own power-up reset and is never driven from sys_rst_o.
module rstctl_top
    import rstctl_pkg::*;
#(
    parameter int MIN_PULSE  = 8,
    parameter int REL_STAGES = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ext_rst_ni,
    input  logic              sw_rst_i,
    input  logic              wdt_to_i,
    input  logic              sleep_i,
    input  logic              idle_i,
    input  logic [LVL_W-1:0]  trap_cur_lvl_i,
    input  logic              trap_new_i,
    input  logic [LVL_W-1:0]  trap_new_lvl_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_wdata_i,
    output logic              sys_rst_o,
    output logic              wake_o,
    output logic [STAT_W-1:0] status_o
);
    logic ext_qual, conflict, wdt_hit, wdt_wake, wdt_rst;
    logic sw_q, trap_q, wake_q;
    logic [STAT_W-1:0] set_vec;

    rstctl_pin_filter #(.MIN_W(MIN_PULSE)) filt_i (
        .clk_i (clk_i), .rst_ni(rst_ni), .pin_ni(ext_rst_ni), .qual_o(ext_qual)
    );

    rstctl_trap_detect trap_i (
        .new_i(trap_new_i), .cur_lvl_i(trap_cur_lvl_i),
        .new_lvl_i(trap_new_lvl_i), .conflict_o(conflict)
    );

    // Split the watchdog event by the core's power state.
    always_comb begin
        wdt_hit  = wdt_to_i & ~(sleep_i | idle_i);
        wdt_wake = wdt_to_i &  (sleep_i | idle_i);
    end

    rstctl_release_sync #(.STAGES(REL_STAGES)) rel_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .hit_i(wdt_hit), .rst_o(wdt_rst)
    );

    // One-cycle reset pulses for software and trap causes, and the wake pulse.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sw_q   <= 1'b0;
            trap_q <= 1'b0;
            wake_q <= 1'b0;
        end else begin
            sw_q   <= sw_rst_i;
            trap_q <= conflict;
            wake_q <= wdt_wake;
        end
    end

    // Map each cause to its flag position.
    always_comb begin
        set_vec            = '0;
        set_vec[FLAG_TRAP] = conflict;
        set_vec[FLAG_EXT]  = ext_qual;
        set_vec[FLAG_SW]   = sw_rst_i;
        set_vec[FLAG_WDT]  = wdt_hit;
    end

    rstctl_status_reg stat_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .set_i(set_vec),
        .wr_i(stat_wr_i), .wdata_i(stat_wdata_i), .stat_o(status_o)
    );

    assign sys_rst_o = ext_qual | sw_q | trap_q | wdt_rst;
    assign wake_o    = wake_q;
endmodule

// File: rtl/rstctl_chk.sv
// Module: property checker for rstctl_top, attached by bind.
// Relates causes at the ports to the reset, wake and status outputs.
module rstctl_chk
    import rstctl_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              sw_rst_i,
    input logic              wdt_to_i,
    input logic              sleep_i,
    input logic              idle_i,
    input logic [LVL_W-1:0]  trap_cur_lvl_i,
    input logic              trap_new_i,
    input logic [LVL_W-1:0]  trap_new_lvl_i,
    input logic              stat_wr_i,
    input logic [STAT_W-1:0] stat_wdata_i,
    input logic              sys_rst_o,
    input logic              wake_o,
    input logic [STAT_W-1:0] status_o
);
    AST_SW_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sw_rst_i |=> (sys_rst_o && status_o[FLAG_SW])); // R3
    AST_WDT_ASYNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wdt_to_i && !sleep_i && !idle_i) |-> sys_rst_o); // R4
    AST_WDT_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wdt_to_i && !sleep_i && !idle_i) |=> status_o[FLAG_WDT]); // R4
    AST_LP_WAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wdt_to_i && (sleep_i || idle_i)) |=> (wake_o && !$rose(status_o[FLAG_WDT]))); // R5
    AST_TRAP_CONFLICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (trap_new_i && trap_cur_lvl_i >= 4'd13 && trap_new_lvl_i > trap_cur_lvl_i)
        |=> (sys_rst_o && status_o[FLAG_TRAP])); // R6
    AST_EXT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[FLAG_EXT]) |-> ($past(stat_wr_i) && !$past(stat_wdata_i[FLAG_EXT]))); // R8
    AST_SW_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[FLAG_SW]) |-> ($past(stat_wr_i) && !$past(stat_wdata_i[FLAG_SW]))); // R8
    AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((status_o & ~FLAG_MASK) == '0)); // R8
endmodule

bind rstctl_top rstctl_chk chk_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sw_rst_i(sw_rst_i), .wdt_to_i(wdt_to_i),
    .sleep_i(sleep_i), .idle_i(idle_i), .trap_cur_lvl_i(trap_cur_lvl_i),
    .trap_new_i(trap_new_i), .trap_new_lvl_i(trap_new_lvl_i),
    .stat_wr_i(stat_wr_i), .stat_wdata_i(stat_wdata_i),
    .sys_rst_o(sys_rst_o), .wake_o(wake_o), .status_o(status_o)
);

// File: tb/rstctl_top_tb_top.sv
`timescale 1ns/1ps
// Bench: sweeps the pin pulse lengths, all trap level pairs and the power states.
// Reset and wake cycles are counted on falling edges.
module rstctl_top_tb_top;
    localparam int MINP = 8;
    localparam int RELS = 2;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic ext_rst_ni = 1'b1, sw_rst_i = 1'b0, wdt_to_i = 1'b0;
    logic sleep_i = 1'b0, idle_i = 1'b0, trap_new_i = 1'b0, stat_wr_i = 1'b0;
    logic [3:0] trap_cur_lvl_i = '0, trap_new_lvl_i = '0;
    logic [15:0] stat_wdata_i = '0;
    logic sys_rst_o, wake_o;
    logic [15:0] status_o;

    int total = 0, bad = 0;
    int rst_cnt = 0, wake_cnt = 0;

    always #4 clk = ~clk;

    rstctl_top #(.MIN_PULSE(MINP), .REL_STAGES(RELS)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .ext_rst_ni(ext_rst_ni), .sw_rst_i(sw_rst_i),
        .wdt_to_i(wdt_to_i), .sleep_i(sleep_i), .idle_i(idle_i),
        .trap_cur_lvl_i(trap_cur_lvl_i), .trap_new_i(trap_new_i),
        .trap_new_lvl_i(trap_new_lvl_i), .stat_wr_i(stat_wr_i),
        .stat_wdata_i(stat_wdata_i), .sys_rst_o(sys_rst_o), .wake_o(wake_o),
        .status_o(status_o)
    );

    // Count reset and wake cycles, sampled on falling edges.
    always @(negedge clk) begin
        if (sys_rst_o) rst_cnt++;
        if (wake_o)    wake_cnt++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic clear_flags();
        stat_wr_i = 1'b1; stat_wdata_i = 16'h0000;
        tick();
        stat_wr_i = 1'b0;
        tick();
        rst_cnt = 0; wake_cnt = 0;
    endtask

    initial begin
        #1200000;
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        tick(3);
        chk(status_o == 0 && !sys_rst_o && !wake_o, "R9 in reset", status_o, 0);
        rst_ni = 1'b1;
        tick();
        chk(status_o == 0 && !sys_rst_o && !wake_o, "R9 after release", status_o, 0);
        rst_cnt = 0; wake_cnt = 0;

        // R1/R2: pulse length sweep around the threshold.
        for (int len = 1; len <= MINP + 4; len++) begin
            clear_flags();
            ext_rst_ni = 1'b0;
            tick(len);
            ext_rst_ni = 1'b1;
            tick(8);
            chk(rst_cnt == ((len >= MINP) ? len - MINP + 1 : 0), "R1 pin reset length",
                rst_cnt, (len >= MINP) ? len - MINP + 1 : 0);
            chk(status_o[7] == (len >= MINP), "R2 pin flag", status_o, (len >= MINP) ? 16'h80 : 0);
        end

        // R3: software strobe.
        clear_flags();
        sw_rst_i = 1'b1; tick(); sw_rst_i = 1'b0; tick(4);
        chk(rst_cnt == 1, "R3 sw reset length", rst_cnt, 1);
        chk(status_o == 16'h0040, "R3 sw flag", status_o, 16'h0040);

        // R4: running watchdog expiry, asynchronous assertion.
        clear_flags();
        wdt_to_i = 1'b1; #1;
        chk(sys_rst_o == 1'b1, "R4 async assert", sys_rst_o, 1);
        tick(); wdt_to_i = 1'b0; tick(5);
        chk(rst_cnt == RELS, "R4 wdt reset length", rst_cnt, RELS);
        chk(status_o == 16'h0010, "R4 wdt flag", status_o, 16'h0010);

        // R5: expiry in each low-power state combination.
        for (int m = 1; m < 4; m++) begin
            clear_flags();
            sleep_i = m[0]; idle_i = m[1];
            wdt_to_i = 1'b1; tick(); wdt_to_i = 1'b0; tick(4);
            chk(wake_cnt == 1, "R5 wake pulse", wake_cnt, 1);
            chk(rst_cnt == 0, "R5 no reset", rst_cnt, 0);
            chk(status_o == 0, "R5 no wdt flag", status_o, 0);
            sleep_i = 1'b0; idle_i = 1'b0;
        end

        // R6: every current/new level pair.
        for (int c = 0; c < 16; c++) begin
            for (int n = 0; n < 16; n++) begin
                bit exp_c;
                exp_c = (c >= 13) && (n >= 13) && (c < n);
                clear_flags();
                trap_cur_lvl_i = 4'(c); trap_new_lvl_i = 4'(n); trap_new_i = 1'b1;
                tick(); trap_new_i = 1'b0; tick(3);
                chk(rst_cnt == int'(exp_c), "R6 trap reset", rst_cnt, int'(exp_c));
                chk(status_o[15] == exp_c, "R6 trap flag", status_o, exp_c ? 16'h8000 : 0);
            end
        end

        // R7: simultaneous software, trap and watchdog causes.
        clear_flags();
        trap_cur_lvl_i = 4'd13; trap_new_lvl_i = 4'd14;
        sw_rst_i = 1'b1; trap_new_i = 1'b1; wdt_to_i = 1'b1;
        tick();
        sw_rst_i = 1'b0; trap_new_i = 1'b0; wdt_to_i = 1'b0;
        tick(5);
        chk(status_o == 16'h8050, "R7 combined flags", status_o, 16'h8050);
        chk(rst_cnt == RELS, "R7 longest cause", rst_cnt, RELS);

        // R8: sticky flags, selective clear, set beats clear, reserved bits.
        clear_flags();
        sw_rst_i = 1'b1; tick(); sw_rst_i = 1'b0; tick(2);
        ext_rst_ni = 1'b0; tick(MINP + 2); ext_rst_ni = 1'b1; tick(6);
        chk(status_o == 16'h00C0, "R8 sticky across reset", status_o, 16'h00C0);
        stat_wr_i = 1'b1; stat_wdata_i = 16'h0040; tick(); stat_wr_i = 1'b0; tick();
        chk(status_o == 16'h0040, "R8 selective clear", status_o, 16'h0040);
        stat_wr_i = 1'b1; stat_wdata_i = 16'hFFFF; tick(); stat_wr_i = 1'b0; tick();
        chk(status_o == 16'h0040, "R8 reserved bits zero", status_o, 16'h0040);
        stat_wr_i = 1'b1; stat_wdata_i = 16'h0000; sw_rst_i = 1'b1;
        tick(); stat_wr_i = 1'b0; sw_rst_i = 1'b0; tick();
        chk(status_o == 16'h0040, "R8 set beats clear", status_o, 16'h0040);
        clear_flags();
        chk(status_o == 16'h0000, "R8 full clear", status_o, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule